// File: doc/BRIEF.md
# Rule 110 Cellular Automaton Row

This block holds a one-dimensional row of single-bit cells. While it runs, every cell takes a new value on each clock edge, all at the same time. The new value follows elementary rule 110, computed from the cell and its two neighbours. The whole row therefore advances one generation per cycle. Asynchronous reset loads a seed with only the rightmost cell set. Evolution then begins on the first clock edge with no further command.

A host sees the row through a window of eight cells, chosen by a block address. The window's contents appear combinationally on an 8-bit output. Pulling the active-low stop input low freezes the row. While the row is frozen, pulling the active-low write strobe low replaces the addressed block with the 8-bit input data at the next clock edge. The row can be preloaded this way before it is released to run again.

Top module: `ca110_row`

## Requirements
- R1: While `stop_n` is 1 and reset is inactive, every one of the CELLS cells (default 256) loads its next-state value on the same rising clock edge, so one full generation completes per cycle.
- R2: Cell index 0 is the rightmost cell, and the left neighbour of cell i is cell i+1. The next value of a cell is looked up from the pattern {left, self, right}: 111→0, 110→1, 101→1, 100→0, 011→1, 010→1, 001→1, 000→0.
- R3: A neighbour beyond either end of the row reads as 0, with no wrap-around. For example, a row whose only set cell is the leftmost one keeps that cell set and leaves cell 0 clear after one generation.
- R4: While `rst_n` is 0, cell 0 holds 1 and every other cell holds 0. The first rising edge with `rst_n` high and `stop_n` high produces generation 1.
- R5: While `stop_n` is 0 and `wr_n` is 1, no cell changes.
- R6: `rd_data` equals cells 8a+7 down to 8a, where a is `blk_addr`, with cell 8a on bit 0. It follows address and state changes in the same cycle, with no register in between.
- R7: A rising edge with `stop_n`=0 and `wr_n`=0 loads `wr_data` into the block at `blk_addr`, with bit k going to cell 8a+k. All other cells keep their values.
- R8: While `stop_n` is 1, `wr_n` has no effect, and the row evolves exactly as in R1.
- R9: With no writes, ten generations after reset block 0 reads 00001101, block 1 reads 00000111, and every other block reads 00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all cell state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; loads the seed |
| stop_n | input | 1 | Active low; 0 freezes evolution and enables host writes |
| wr_n | input | 1 | Active-low block write strobe, honoured only while stopped |
| blk_addr | input | 5 | Selects an 8-cell block; 0 is the rightmost block |
| wr_data | input | 8 | Data for the addressed block, bit 0 to its rightmost cell |
| rd_data | output | 8 | Current contents of the addressed block |

## Verification
A wrong cell value does not stay hidden. Under rule 110 it spreads into neighbouring cells as the row evolves. It shows up on `rd_data` in the same cycle whenever its block is addressed. The bench therefore compares the addressed block against a behavioural model after every edge. It also sweeps all 32 blocks after each phase, so a corrupted cell is reported within one sweep of the generation in which it appears. A wrong boundary value or a missed write would otherwise stay confined to one end of the row.

// File: rtl/ca110_pkg.sv
package ca110_pkg;

  // Rule 110 next state from {left, self, right}
  function automatic logic rule110(input logic l, input logic s, input logic r);
    return (s | r) & ~(l & s & r);
  endfunction

endpackage

// File: rtl/ca110_next.sv
module ca110_next #(
  parameter int CELLS = 256
) (
  input  logic [CELLS-1:0] cells,
  output logic [CELLS-1:0] nxt
);
  import ca110_pkg::*;

  // zero padding on both ends: no wrap-around
  logic [CELLS+1:0] pad;
  assign pad = {1'b0, cells, 1'b0};

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    assign nxt[i] = rule110(pad[i+2], pad[i+1], pad[i]);
  end
endmodule

// File: rtl/ca110_rdmux.sv
module ca110_rdmux #(
  parameter int CELLS = 256,
  parameter int BLK   = 8,
  localparam int NBLK = CELLS / BLK,
  localparam int AW   = $clog2(NBLK)
) (
  input  logic [CELLS-1:0] cells,
  input  logic [AW-1:0]    addr,
  output logic [BLK-1:0]   rd
);
  logic [BLK-1:0] blocks [NBLK];

  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    assign blocks[g] = cells[g*BLK +: BLK];
  end

  assign rd = blocks[addr];
endmodule

// File: rtl/ca110_wrdec.sv
module ca110_wrdec #(
  parameter int NBLK = 32,
  localparam int AW  = $clog2(NBLK)
) (
  input  logic            en,
  input  logic [AW-1:0]   addr,
  output logic [NBLK-1:0] sel
);
  for (genvar g = 0; g < NBLK; g++) begin : g_sel
    assign sel[g] = en && (addr == AW'(g));
  end
endmodule

// File: rtl/ca110_row.sv
module ca110_row #(
  parameter int CELLS = 256,
  parameter int BLK   = 8,
  localparam int NBLK = CELLS / BLK,
  localparam int AW   = $clog2(NBLK)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           stop_n,
  input  logic           wr_n,
  input  logic [AW-1:0]  blk_addr,
  input  logic [BLK-1:0] wr_data,
  output logic [BLK-1:0] rd_data
);
  localparam logic [CELLS-1:0] SEED = CELLS'(1);

  logic [CELLS-1:0] cells;
  logic [CELLS-1:0] nxt;
  logic [NBLK-1:0]  wr_sel;
  logic             evolve;
  logic             wr_fire;

  assign evolve  = stop_n;
  assign wr_fire = !stop_n && !wr_n;

  ca110_next #(.CELLS(CELLS)) u_next (
    .cells (cells),
    .nxt   (nxt)
  );

  ca110_wrdec #(.NBLK(NBLK)) u_wrdec (
    .en   (wr_fire),
    .addr (blk_addr),
    .sel  (wr_sel)
  );

  ca110_rdmux #(.CELLS(CELLS), .BLK(BLK)) u_rdmux (
    .cells (cells),
    .addr  (blk_addr),
    .rd    (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cells <= SEED;
    end else if (evolve) begin
      cells <= nxt;
    end else begin
      for (int g = 0; g < NBLK; g++) begin
        if (wr_sel[g]) cells[g*BLK +: BLK] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/ca110_row_chk.sv
module ca110_row_chk #(
  parameter int CELLS = 256,
  parameter int BLK   = 8,
  localparam int NBLK = CELLS / BLK,
  localparam int AW   = $clog2(NBLK)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop_n,
  input logic             wr_n,
  input logic [AW-1:0]    blk_addr,
  input logic [BLK-1:0]   wr_data,
  input logic [BLK-1:0]   rd_data,
  input logic [CELLS-1:0] cells,
  input logic [CELLS-1:0] nxt,
  input logic [NBLK-1:0]  wr_sel
);
  localparam logic [CELLS-1:0] SEED = CELLS'(1);
  localparam logic [CELLS-1:0] LOW_MASK = CELLS'({BLK{1'b1}});

  assert_seed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> cells == SEED);

  assert_generation_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_n |=> cells == $past(nxt));

  assert_halt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_n && wr_n) |=> $stable(cells));

  assert_read_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data == BLK'(cells >> (int'(blk_addr) * BLK)));

  assert_write_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_n && !wr_n) |=>
      BLK'(cells >> (int'($past(blk_addr)) * BLK)) == $past(wr_data));

  assert_write_others_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_n && !wr_n) |=>
      ((cells ^ $past(cells)) & ~(LOW_MASK << (int'($past(blk_addr)) * BLK))) == '0);

  assert_write_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel) && (stop_n -> (wr_sel == '0)));
endmodule

bind ca110_row ca110_row_chk #(.CELLS(CELLS), .BLK(BLK)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .stop_n   (stop_n),
  .wr_n     (wr_n),
  .blk_addr (blk_addr),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .cells    (cells),
  .nxt      (nxt),
  .wr_sel   (wr_sel)
);

// File: tb/ca110_row_tb.sv
`timescale 1ns/1ps
module ca110_row_tb;
  localparam int N  = 256;
  localparam int NB = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop_n = 1'b1;
  logic       wr_n = 1'b1;
  logic [4:0] blk_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  bit model [N];

  always #2 clk = ~clk;

  ca110_row u_dut (
    .clk(clk), .rst_n(rst_n), .stop_n(stop_n), .wr_n(wr_n),
    .blk_addr(blk_addr), .wr_data(wr_data), .rd_data(rd_data)
  );

  function automatic logic [7:0] model_blk(input int a);
    logic [7:0] v;
    for (int k = 0; k < 8; k++) v[k] = model[a*8+k];
    return v;
  endfunction

  task automatic model_seed();
    for (int i = 0; i < N; i++) model[i] = (i == 0);
  endtask

  task automatic model_evolve();
    bit nx [N];
    for (int i = 0; i < N; i++) begin
      int l, s, r, idx;
      l = (i == N-1) ? 0 : int'(model[i+1]);
      s = int'(model[i]);
      r = (i == 0) ? 0 : int'(model[i-1]);
      idx = l*4 + s*2 + r;
      nx[i] = ((110 >> idx) & 1) == 1;
    end
    for (int i = 0; i < N; i++) model[i] = nx[i];
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rd_data=%b expected=%b (t=%0t)", req, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, update model at posedge, check at next negedge
  task automatic step(input bit s, input bit w, input int a, input logic [7:0] d,
                      input string req);
    stop_n = s; wr_n = w; blk_addr = 5'(a); wr_data = d;
    @(posedge clk);
    if (!rst_n) model_seed();
    else if (s) model_evolve();
    else if (!w) for (int k = 0; k < 8; k++) model[a*8+k] = d[k];
    @(negedge clk);
    chk(req, rd_data, model_blk(a));
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < NB; a++) step(1'b0, 1'b1, a, 8'h5A, req);
  endtask

  initial begin
    model_seed();
    @(negedge clk);
    // reset state, R4
    for (int a = 0; a < NB; a++) step(1'b1, 1'b0, a, 8'hFF, "R4 reset seed");
    rst_n = 1'b1;
    // ten generations, R1 R2 R4
    for (int g = 0; g < 10; g++) step(1'b1, 1'b1, g % 2, 8'h00, "R1 R2 R4 evolve");
    step(1'b0, 1'b1, 0, 8'h00, "R9");
    chk("R9 block0", rd_data, 8'b00001101);
    step(1'b0, 1'b1, 1, 8'h00, "R9");
    chk("R9 block1", rd_data, 8'b00000111);
    for (int a = 2; a < NB; a++) begin
      step(1'b0, 1'b1, a, 8'h00, "R9");
      chk("R9 upper block", rd_data, 8'h00);
    end
    // halted with stray data: R5
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, i, 8'hC3, "R5 halt hold");
    sweep("R5 sweep");
    // block writes: R7
    step(1'b0, 1'b0, 0, 8'b00000111, "R7 write");
    step(1'b0, 1'b0, 1, 8'b11100110, "R7 write");
    step(1'b0, 1'b0, 2, 8'b11010111, "R7 write");
    step(1'b0, 1'b0, 17, 8'hA5, "R7 write");
    sweep("R6 R7 sweep");
    // write strobe while running: R8
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0, i % 4, 8'hFF, "R8 wr ignored");
    sweep("R8 sweep");
    // boundaries: R3
    for (int a = 0; a < NB; a++) step(1'b0, 1'b0, a, 8'h00, "R7 clear");
    step(1'b0, 1'b0, 31, 8'b10000000, "R7 write");
    step(1'b1, 1'b1, 0, 8'h00, "R3 evolve");
    chk("R3 right edge no wrap", rd_data, 8'h00);
    step(1'b0, 1'b1, 31, 8'h00, "R3");
    chk("R3 left edge", rd_data, 8'b10000000);
    step(1'b0, 1'b0, 0, 8'b00000001, "R7 write");
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, (i % 2) ? 31 : 0, 8'h00, "R2 R3 evolve");
    sweep("R3 sweep");
    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      bit s, w;
      s = ($urandom % 4) != 0;
      w = ($urandom % 2) != 0;
      step(s, w, int'($urandom % NB), 8'($urandom), "R1 R2 R5 R6 R7 R8 mixed");
    end
    sweep("R6 final sweep");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule